// File: doc/BRIEF.md
# Associative Cache Victim Selector

This block picks the way to evict from one set of an N-way associative cache. It keeps a small replacement record for every set and looks at the record of the set named by `set_idx`. It then drives the chosen way on `victim_way` in the same cycle, with no register between the index and the output. The cache controller reports each lookup with a one-cycle strobe, `acc_valid`. A hit carries the way that matched. A miss carries the way that was refilled, and that way then counts as valid. The victim suggestion is used only on a miss.

The `POLICY` parameter picks one of three replacement schemes at elaboration. Value 0 is a binary-tree approximation of least-recently-used. Value 1 is a plain per-set round-robin pointer. Value 2 is round-robin that steps over the most recently touched way. Under every scheme, a set that still has an empty way fills it before any policy decision is made. Tags, data arrays and the refill path belong to the surrounding cache.

Top module: `victim_select`

## Requirements
- R1: After reset every way of every set is invalid, all replacement state is zero, and `victim_way` reads 0 whatever `set_idx` is.
- R2: While the indexed set holds at least one invalid way, `victim_way` is the lowest-numbered invalid way, under every policy.
- R3: A miss (`acc_valid`=1, `acc_hit`=0) marks `fill_way` valid in the indexed set only. No other set changes.
- R4: Tree policy (`POLICY`=0): every access updates the tree, whether a hit (touching `hit_way`) or a miss (touching `fill_way`). Each tree bit on the path to the touched way is set to point away from it. In a full set, the next victim is therefore never the way just touched.
- R5: Tree policy: the tree nodes are stored in heap order, with the root first and the children of node n at 2n+1 and 2n+2. The victim is found by walking down from the root. A node bit of 0 descends to the lower-numbered half and 1 to the upper half, so the root decides the way number's most significant bit.
- R6: Round-robin (`POLICY`=1): each set has a pointer that starts at 0 and advances by one, modulo the way count, on every miss in that set. In a full set the victim is the pointer.
- R7: Round-robin: a hit changes neither the pointer nor `victim_way`.
- R8: Skip-MRU round-robin (`POLICY`=2): the pointer advances as in R6. In a full set the victim is the pointer, unless the pointer equals the most recently used way. In that case the victim is the next way, modulo the way count.
- R9: Skip-MRU: the per-set most-recently-used record takes the touched way on every access, hit or miss. It resets to 0.
- R10: `victim_way` is combinational from `set_idx` and the stored state. It changes in the same cycle as `set_idx`, with no clock edge.
- R11: A cycle with `acc_valid` low changes no state, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | log2(NUM_SETS) | Set being looked up |
| acc_valid | input | 1 | One lookup is reported this cycle |
| acc_hit | input | 1 | 1 = hit, 0 = miss with refill |
| hit_way | input | log2(NUM_WAYS) | Matching way on a hit |
| fill_way | input | log2(NUM_WAYS) | Refilled way on a miss |
| victim_way | output | log2(NUM_WAYS) | Way to evict from the indexed set |

## Verification
The checker holds its own copy of the valid bits, built from the port traffic alone. From it, the checker checks on every cycle that:
- the victim is the lowest empty way while one exists;
- an idle cycle leaves the victim steady;
- a round-robin hit leaves the victim alone, and a round-robin miss in a full set steps the victim by one;
- the tree and skip-MRU schemes never name the way touched in the previous cycle.

The exact tree walk, the skip-over decision when the pointer sits on the MRU way, and the independence of sets appear only in the bench's scenarios. There, a bench model of all three policies is compared with the outputs over long mixed hit/miss streams.

// File: rtl/victim_select_pkg.sv
package victim_select_pkg;

   typedef enum logic [1:0] {
      POL_TREE       = 2'd0,
      POL_ROUND      = 2'd1,
      POL_ROUND_SKIP = 2'd2
   } repl_policy_e;

   localparam int unsigned MAX_WAYS = 64;
   localparam int unsigned MAX_SETS = 1024;

endpackage

// File: rtl/victim_select_valid.sv
module victim_select_valid #(
   parameter  int unsigned NUM_SETS = 4,
   parameter  int unsigned NUM_WAYS = 4,
   localparam int unsigned SET_W    = $clog2(NUM_SETS),
   localparam int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   input  logic             fill_en,
   input  logic [WAY_W-1:0] fill_way,
   output logic             any_invalid,
   output logic [WAY_W-1:0] first_invalid
);

   logic [NUM_WAYS-1:0] vld_q [NUM_SETS];
   logic [NUM_WAYS-1:0] cur_vld;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[s] <= '0;
         end else if (fill_en && (set_idx == SET_W'(s))) begin
            vld_q[s][fill_way] <= 1'b1;
         end
      end
   end

   assign cur_vld     = vld_q[set_idx];
   assign any_invalid = ~&cur_vld;

   // Scan from the top so the lowest empty way is the last one written.
   always_comb begin
      first_invalid = '0;
      for (int w = int'(NUM_WAYS) - 1; w >= 0; w--) begin
         if (!cur_vld[w]) begin
            first_invalid = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/victim_select_plru.sv
module victim_select_plru #(
   parameter  int unsigned NUM_SETS = 4,
   parameter  int unsigned NUM_WAYS = 4,
   localparam int unsigned SET_W    = $clog2(NUM_SETS),
   localparam int unsigned WAY_W    = $clog2(NUM_WAYS),
   localparam int unsigned NODES    = NUM_WAYS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   input  logic             upd_en,
   input  logic [WAY_W-1:0] upd_way,
   output logic [WAY_W-1:0] pick_way
);

   logic [NODES-1:0] tree_q [NUM_SETS];
   logic [NODES-1:0] cur_tree;
   logic [NODES-1:0] path_mask;
   logic [NODES-1:0] away_bits;
   logic [NODES-1:0] tree_nxt;

   assign cur_tree = tree_q[set_idx];

   // Node n sits at depth floor(log2(n+1)), at position n+1-2^depth within its level.
   for (genvar n = 0; n < NODES; n++) begin : g_node
      localparam int unsigned LVL = $clog2(n + 2) - 1;
      localparam int unsigned POS = n + 1 - (1 << LVL);
      assign path_mask[n] = ((upd_way >> (WAY_W - LVL)) == WAY_W'(POS));
      assign away_bits[n] = ~upd_way[WAY_W-1-LVL];
   end

   assign tree_nxt = (cur_tree & ~path_mask) | (away_bits & path_mask);

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tree_q[s] <= '0;
         end else if (upd_en && (set_idx == SET_W'(s))) begin
            tree_q[s] <= tree_nxt;
         end
      end
   end

   always_comb begin
      int   node;
      logic dir;
      node = 0;
      for (int l = 0; l < int'(WAY_W); l++) begin
         dir = 1'b0;
         for (int n = 0; n < int'(NODES); n++) begin
            if (n == node) begin
               dir = cur_tree[n];
            end
         end
         node = 2 * node + 1 + (dir ? 1 : 0);
      end
      pick_way = WAY_W'(node - int'(NODES));
   end

endmodule

// File: rtl/victim_select_rr.sv
module victim_select_rr #(
   parameter  int unsigned NUM_SETS = 4,
   parameter  int unsigned NUM_WAYS = 4,
   parameter  bit          SKIP_MRU = 1'b0,
   localparam int unsigned SET_W    = $clog2(NUM_SETS),
   localparam int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way,
   input  logic             adv_en,
   output logic [WAY_W-1:0] pick_way
);

   logic [WAY_W-1:0] ptr_q [NUM_SETS];
   logic [WAY_W-1:0] cur_ptr;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q[s] <= '0;
         end else if (adv_en && (set_idx == SET_W'(s))) begin
            ptr_q[s] <= ptr_q[s] + WAY_W'(1);
         end
      end
   end

   assign cur_ptr = ptr_q[set_idx];

   if (SKIP_MRU) begin : g_skip
      logic [WAY_W-1:0] mru_q [NUM_SETS];
      logic [WAY_W-1:0] cur_mru;

      for (genvar s = 0; s < NUM_SETS; s++) begin : g_mru
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mru_q[s] <= '0;
            end else if (touch_en && (set_idx == SET_W'(s))) begin
               mru_q[s] <= touch_way;
            end
         end
      end

      assign cur_mru  = mru_q[set_idx];
      assign pick_way = (cur_ptr == cur_mru) ? cur_ptr + WAY_W'(1) : cur_ptr;
   end else begin : g_plain
      logic unused_touch;
      assign unused_touch = ^{touch_en, touch_way};
      assign pick_way     = cur_ptr;
   end

endmodule

// File: rtl/victim_select.sv
module victim_select
   import victim_select_pkg::*;
#(
   parameter  int unsigned  NUM_SETS = 4,
   parameter  int unsigned  NUM_WAYS = 4,
   parameter  repl_policy_e POLICY   = POL_TREE,
   localparam int unsigned  SET_W    = $clog2(NUM_SETS),
   localparam int unsigned  WAY_W    = $clog2(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   input  logic             acc_valid,
   input  logic             acc_hit,
   input  logic [WAY_W-1:0] hit_way,
   input  logic [WAY_W-1:0] fill_way,
   output logic [WAY_W-1:0] victim_way
);

   if (NUM_WAYS < 2 || NUM_WAYS > MAX_WAYS || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("victim_select: NUM_WAYS must be a power of two between 2 and MAX_WAYS");
   end
   if (NUM_SETS < 2 || NUM_SETS > MAX_SETS || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("victim_select: NUM_SETS must be a power of two between 2 and MAX_SETS");
   end

   logic             miss_fill;
   logic [WAY_W-1:0] touched_way;
   logic             any_invalid;
   logic [WAY_W-1:0] first_invalid;
   logic [WAY_W-1:0] policy_way;

   assign miss_fill   = acc_valid & ~acc_hit;
   assign touched_way = acc_hit ? hit_way : fill_way;

   victim_select_valid #(
      .NUM_SETS (NUM_SETS),
      .NUM_WAYS (NUM_WAYS)
   ) u_valid (
      .clk           (clk),
      .rst_n         (rst_n),
      .set_idx       (set_idx),
      .fill_en       (miss_fill),
      .fill_way      (fill_way),
      .any_invalid   (any_invalid),
      .first_invalid (first_invalid)
   );

   if (POLICY == POL_TREE) begin : g_tree
      victim_select_plru #(
         .NUM_SETS (NUM_SETS),
         .NUM_WAYS (NUM_WAYS)
      ) u_plru (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_idx  (set_idx),
         .upd_en   (acc_valid),
         .upd_way  (touched_way),
         .pick_way (policy_way)
      );
   end else begin : g_round
      victim_select_rr #(
         .NUM_SETS (NUM_SETS),
         .NUM_WAYS (NUM_WAYS),
         .SKIP_MRU (POLICY == POL_ROUND_SKIP)
      ) u_rr (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_idx   (set_idx),
         .touch_en  (acc_valid),
         .touch_way (touched_way),
         .adv_en    (miss_fill),
         .pick_way  (policy_way)
      );
   end

   assign victim_way = any_invalid ? first_invalid : policy_way;

endmodule

// File: rtl/victim_select_chk.sv
module victim_select_chk
   import victim_select_pkg::*;
#(
   parameter  int unsigned  NUM_SETS = 4,
   parameter  int unsigned  NUM_WAYS = 4,
   parameter  repl_policy_e POLICY   = POL_TREE,
   localparam int unsigned  SET_W    = $clog2(NUM_SETS),
   localparam int unsigned  WAY_W    = $clog2(NUM_WAYS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SET_W-1:0] set_idx,
   input logic             acc_valid,
   input logic             acc_hit,
   input logic [WAY_W-1:0] hit_way,
   input logic [WAY_W-1:0] fill_way,
   input logic [WAY_W-1:0] victim_way
);

   localparam logic [NUM_WAYS-1:0] ONE = NUM_WAYS'(1);

   logic [NUM_WAYS-1:0] shadow_q [NUM_SETS];
   logic [NUM_WAYS-1:0] cur_shadow;
   logic [NUM_WAYS-1:0] below_mask;
   logic                cur_full;
   logic [WAY_W-1:0]    touched;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q[s] <= '0;
         end else if (acc_valid && !acc_hit && (set_idx == SET_W'(s))) begin
            shadow_q[s][fill_way] <= 1'b1;
         end
      end
   end

   assign cur_shadow = shadow_q[set_idx];
   assign cur_full   = &cur_shadow;
   assign below_mask = (ONE << victim_way) - ONE;
   assign touched    = acc_hit ? hit_way : fill_way;

   a_r1_reset_victim_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (victim_way == '0));

   a_r2_lowest_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_full |-> (!cur_shadow[victim_way] && ((cur_shadow & below_mask) == below_mask)));

   a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!acc_valid) && $stable(set_idx)) |-> $stable(victim_way));

   a_r7_round_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (POLICY == POL_ROUND && $past(acc_valid && acc_hit) && $stable(set_idx))
         |-> $stable(victim_way));

   a_r6_round_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (POLICY == POL_ROUND && $past(acc_valid && !acc_hit) && $stable(set_idx) && $past(cur_full))
         |-> (victim_way == $past(victim_way) + WAY_W'(1)));

   a_r4_tree_points_away: assert property (@(posedge clk) disable iff (!rst_n)
      (POLICY == POL_TREE && $past(acc_valid) && $stable(set_idx) && cur_full)
         |-> (victim_way != $past(touched)));

   a_r8_skip_avoids_mru: assert property (@(posedge clk) disable iff (!rst_n)
      (POLICY == POL_ROUND_SKIP && $past(acc_valid) && $stable(set_idx) && cur_full)
         |-> (victim_way != $past(touched)));

endmodule

bind victim_select victim_select_chk #(
   .NUM_SETS (NUM_SETS),
   .NUM_WAYS (NUM_WAYS),
   .POLICY   (POLICY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .set_idx    (set_idx),
   .acc_valid  (acc_valid),
   .acc_hit    (acc_hit),
   .hit_way    (hit_way),
   .fill_way   (fill_way),
   .victim_way (victim_way)
);

// File: tb/test_victim_select.sv
module test_victim_select;
   import victim_select_pkg::*;

   localparam int SETS = 4;
   localparam int WAYS = 4;
   localparam int LV   = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] set_idx = '0;
   logic       acc_valid = 1'b0;
   logic       acc_hit = 1'b0;
   logic [1:0] hit_way = '0;
   logic [1:0] fill_way = '0;
   logic [1:0] v_tree, v_round, v_skip;

   int checks = 0;
   int fails  = 0;

   bit mv [SETS][WAYS];
   bit mt [SETS][WAYS-1];
   int mp [SETS];
   int mm [SETS];

   always #10 clk = ~clk;

   victim_select #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(POL_TREE)) i_victim_select (
      .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_valid(acc_valid), .acc_hit(acc_hit),
      .hit_way(hit_way), .fill_way(fill_way), .victim_way(v_tree));

   victim_select #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(POL_ROUND)) i_victim_select_round (
      .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_valid(acc_valid), .acc_hit(acc_hit),
      .hit_way(hit_way), .fill_way(fill_way), .victim_way(v_round));

   victim_select #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(POL_ROUND_SKIP)) i_victim_select_skip (
      .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_valid(acc_valid), .acc_hit(acc_hit),
      .hit_way(hit_way), .fill_way(fill_way), .victim_way(v_skip));

   function automatic int first_inv(int s);
      for (int w = 0; w < WAYS; w++) if (!mv[s][w]) return w;
      return -1;
   endfunction

   function automatic int expect_way(int pol, int s);
      int fi;
      int node;
      fi = first_inv(s);
      if (fi >= 0) return fi;
      if (pol == 0) begin
         node = 0;
         for (int l = 0; l < LV; l++) node = 2 * node + 1 + int'(mt[s][node]);
         return node - (WAYS - 1);
      end
      if (pol == 1) return mp[s];
      return (mp[s] == mm[s]) ? (mp[s] + 1) % WAYS : mp[s];
   endfunction

   task automatic model_clear();
      for (int s = 0; s < SETS; s++) begin
         mp[s] = 0;
         mm[s] = 0;
         for (int w = 0; w < WAYS; w++) mv[s][w] = 1'b0;
         for (int n = 0; n < WAYS - 1; n++) mt[s][n] = 1'b0;
      end
   endtask

   task automatic model_update(int s, bit h, int hw, int fw);
      int t;
      int node;
      int d;
      t = h ? hw : fw;
      if (!h) begin
         mv[s][fw] = 1'b1;
         mp[s] = (mp[s] + 1) % WAYS;
      end
      node = 0;
      for (int l = 0; l < LV; l++) begin
         d = (t >> (LV - 1 - l)) & 1;
         mt[s][node] = (d == 0);
         node = 2 * node + 1 + d;
      end
      mm[s] = t;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s set=%0d actual=%0d expected=%0d", tag, set_idx, act, exp);
      end
   endtask

   task automatic check_set(string tt, string tr, string tn);
      int s;
      s = int'(set_idx);
      chk(tt, int'(v_tree),  expect_way(0, s));
      chk(tr, int'(v_round), expect_way(1, s));
      chk(tn, int'(v_skip),  expect_way(2, s));
   endtask

   task automatic apply(int s, bit v, bit h, int hw, int fw, string tt, string tr, string tn);
      @(negedge clk);
      set_idx   = 2'(s);
      acc_valid = v;
      acc_hit   = h;
      hit_way   = 2'(hw);
      fill_way  = 2'(fw);
      #1;
      check_set(tt, tr, tn);
      @(posedge clk);
      if (v) model_update(s, h, hw, fw);
   endtask

   task automatic peek(int s, string tt, string tr, string tn);
      @(negedge clk);
      set_idx   = 2'(s);
      acc_valid = 1'b0;
      #1;
      check_set(tt, tr, tn);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n     = 1'b0;
      acc_valid = 1'b0;
      model_clear();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic random_phase(int n);
      int  s;
      bit  v;
      bit  h;
      bool_full_tags: begin end
      for (int i = 0; i < n; i++) begin
         s = $urandom_range(0, SETS - 1);
         v = ($urandom_range(0, 9) != 0);
         h = 1'($urandom_range(0, 1));
         if (first_inv(s) >= 0)
            apply(s, v, h, $urandom_range(0, WAYS - 1), $urandom_range(0, WAYS - 1), "R2", "R2", "R2");
         else
            apply(s, v, h, $urandom_range(0, WAYS - 1), $urandom_range(0, WAYS - 1), "R5", "R6", "R8");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      model_clear();
      do_reset();

      // R1: every set reads way 0 after reset
      for (int s = 0; s < SETS; s++) peek(s, "R1", "R1", "R1");

      // R3: a fill in set 1 leaves set 0 untouched
      apply(1, 1'b1, 1'b0, 0, 0, "R3", "R3", "R3");
      peek(0, "R3", "R3", "R3");
      peek(1, "R3", "R3", "R3");

      // Fill set 2 completely, then probe hits
      for (int w = 0; w < WAYS; w++) apply(2, 1'b1, 1'b0, 0, w, "R2", "R2", "R2");
      peek(2, "R5", "R6", "R8");
      apply(2, 1'b1, 1'b1, expect_way(0, 2), 0, "R5", "R6", "R8");
      peek(2, "R4", "R7", "R9");
      apply(2, 1'b1, 1'b1, expect_way(2, 2), 0, "R4", "R7", "R9");
      peek(2, "R4", "R7", "R9");
      apply(2, 1'b1, 1'b1, expect_way(1, 2), 0, "R4", "R7", "R9");
      peek(2, "R4", "R7", "R8");

      // R11: idle cycles with busy side inputs change nothing
      for (int i = 0; i < 8; i++) apply(2, 1'b0, 1'(i), i % WAYS, (i + 1) % WAYS, "R11", "R11", "R11");
      peek(2, "R11", "R11", "R11");

      // Misses on a full set: pointer steps and wraps
      for (int i = 0; i < 6; i++) apply(2, 1'b1, 1'b0, 0, i % WAYS, "R5", "R6", "R8");
      peek(2, "R4", "R6", "R8");

      random_phase(3000);

      // R10: output follows the index with no clock edge
      for (int s = 0; s < SETS; s++) peek(s, "R10", "R10", "R10");
      for (int s = SETS - 1; s >= 0; s--) peek(s, "R10", "R10", "R10");

      do_reset();
      for (int s = 0; s < SETS; s++) peek(s, "R1", "R1", "R1");
      random_phase(2000);
      for (int s = 0; s < SETS; s++) peek(s, "R10", "R10", "R10");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule